// File: doc/BRIEF.md
# Burst-Locked Chroma Subcarrier Generator

This block produces a two-level colour subcarrier for a video overlay path. It runs from a reference clock at exactly seven times the subcarrier rate (about 25.056818 MHz for a 3.579545 MHz subcarrier). A phase counter steps through seven positions and wraps, so every subcarrier cycle has the same shape. The square wave is decoded from the counter position.

There is no phase-locked loop. Once per line the surrounding logic sends a burst-restart strobe together with a restart phase. The counter jumps to that phase, which removes any drift picked up over the previous line. For NTSC a line holds 227.5 subcarrier cycles, so the burst phase alternates by half a cycle from line to line. The caller supplies the restart phase that matches each line.

Hue is set by stalling. A hue-step request with a count N freezes the counter for N reference cycles, which delays the output phase by N sevenths of a cycle. An enable input forces the chroma output low while the counter keeps running, so phase alignment is kept.

Top module: `chroma_subcarrier_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, phase_idx is 0; with en low, chroma_out is 0.
- R2: With no burst and no stall, phase_idx rises by one on every reference clock and goes from 6 back to 0, giving a period of 7 cycles.
- R3: With en high, chroma_out is 1 when phase_idx is 0, 1 or 2, and 0 when phase_idx is 3, 4, 5 or 6.
- R4: With en low, chroma_out is 0 and phase_idx keeps advancing as in R2.
- R5: A clock edge with burst_restart high loads restart_phase into phase_idx. Counting resumes on the following edge.
- R6: A restart_phase of 7 loads phase 0.
- R7: A hue request with hue_steps N in 1..6, taken while no stall is active, holds phase_idx for N clock edges starting with the edge that takes it. The phase then trails free-running by N steps.
- R8: A hue request with hue_steps 0 has no effect on phase_idx.
- R9: A hue request that arrives while a stall is still active is ignored.
- R10: A hue_steps value of 7 is treated as 6.
- R11: burst_restart takes priority: it ends an active stall, and a hue request on the same edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, seven times the subcarrier rate |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_restart | input | 1 | One-cycle strobe per line that reloads the phase |
| restart_phase | input | 3 | Phase loaded on a burst strobe, 0..6 (7 means 0) |
| hue_req | input | 1 | Request to stall the phase counter |
| hue_steps | input | 3 | Stall length in reference cycles, 0..6 (7 means 6) |
| en | input | 1 | Output enable; low forces chroma_out to 0 |
| chroma_out | output | 1 | Square-wave subcarrier |
| phase_idx | output | 3 | Current phase position, 0..6 |

## Verification
The counter is exercised free-running across two full wraps, with the output enabled and then disabled. This separates the counting from the output gating. Burst strobes are applied with every restart value, including the out-of-range 7. This shows that loading and resuming are distinct steps. Stall requests are tried with counts 0, a middle value, the full six and the clamped 7. A second request is sent during an active stall, and a burst is applied mid-stall and on the same edge as a request. The final phase offset after each case shows whether a request was taken, ignored, clamped or cancelled.

// File: rtl/chroma_pkg.sv
// Package: shared constants and helpers for the chroma subcarrier generator.
// Assumes one phase step per reference-clock cycle.
package chroma_pkg;
    parameter int unsigned DEF_PHASES = 7;   // reference cycles per subcarrier cycle
    parameter int unsigned DEF_HIGH   = 3;   // phases with the output high

    // Clamp an integer request to the range 0..limit.
    function automatic int unsigned clamp_to(input int unsigned v, input int unsigned limit);
        return (v > limit) ? limit : v;
    endfunction
endpackage

// File: rtl/chroma_stall_ctl.sv
// Module: hue stall controller. Takes a stall request of N cycles and asserts
// hold_o for N consecutive edges, starting with the edge that accepts it.
// Assumes burst_i has priority: it cancels any stall and blocks a request.
module chroma_stall_ctl #(
    parameter int unsigned PHASES = chroma_pkg::DEF_PHASES,
    localparam int unsigned PW    = $clog2(PHASES),
    localparam int unsigned MAXN  = PHASES - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_i,
    input  logic          hue_req_i,
    input  logic [PW-1:0] hue_steps_i,
    output logic          hold_o
);
    logic [PW-1:0] left_q;
    logic [PW-1:0] steps_clamped;
    logic          busy;
    logic          accept;

    // Clamp the requested count and decide whether this edge takes a request.
    always_comb begin
        steps_clamped = PW'(chroma_pkg::clamp_to(int'(hue_steps_i), MAXN));
        busy          = (left_q != '0);
        accept        = hue_req_i && (steps_clamped != '0) && !busy && !burst_i;
        hold_o        = busy || accept;
    end

    // Count the remaining stalled edges after the accepting one.
    always_ff @(posedge clk) begin
        if (!rst_n)        left_q <= '0;
        else if (burst_i)  left_q <= '0;
        else if (accept)   left_q <= steps_clamped - PW'(1);
        else if (busy)     left_q <= left_q - PW'(1);
    end

    assert_stall_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q != '0 && !burst_i) |=> (left_q == $past(left_q) - PW'(1)));
    assert_burst_cancels_R11: assert property (@(posedge clk) disable iff (!rst_n)
        burst_i |=> (left_q == '0));
    assert_stall_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        left_q < PW'(MAXN));
endmodule

// File: rtl/chroma_phase_ctr.sv
// Module: modulo-PHASES phase counter. Reloads on a burst strobe and freezes
// while hold_i is high. Assumes restart values above PHASES-1 mean phase 0.
module chroma_phase_ctr #(
    parameter int unsigned PHASES = chroma_pkg::DEF_PHASES,
    localparam int unsigned PW    = $clog2(PHASES),
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_i,
    input  logic [PW-1:0] restart_phase_i,
    input  logic          hold_i,
    output logic [PW-1:0] phase_o
);
    logic [PW-1:0] phase_q;
    logic [PW-1:0] restart_safe;

    // Map an out-of-range restart value onto phase 0.
    always_comb restart_safe = (restart_phase_i > LAST) ? '0 : restart_phase_i;

    // Advance, hold or reload the phase each reference cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase_q <= '0;
        else if (burst_i)      phase_q <= restart_safe;
        else if (!hold_i)      phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
    end

    assign phase_o = phase_q;

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
    assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !burst_i) |=> $stable(phase_q));
    assert_restart_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_i && restart_phase_i <= LAST) |=> (phase_q == $past(restart_phase_i)));
    assert_restart_oob_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_i && restart_phase_i > LAST) |=> (phase_q == '0));
endmodule

// File: rtl/chroma_wave_shaper.sv
// Module: decodes the phase into a two-level square wave, gated by enable.
// Assumes the high window is phases 0..HIGH-1.
module chroma_wave_shaper #(
    parameter int unsigned PHASES = chroma_pkg::DEF_PHASES,
    parameter int unsigned HIGH   = chroma_pkg::DEF_HIGH,
    localparam int unsigned PW    = $clog2(PHASES)
) (
    input  logic [PW-1:0] phase_i,
    input  logic          en_i,
    output logic          wave_o
);
    // High inside the window, forced low when disabled.
    always_comb wave_o = en_i && (phase_i < PW'(HIGH));
endmodule

// File: rtl/chroma_subcarrier_gen.sv
// Module: top of the burst-locked chroma subcarrier generator. The phase is
// realigned by a per-line burst strobe and retarded by counted stalls.
// Assumes clk runs at PHASES times the subcarrier rate.
module chroma_subcarrier_gen #(
    parameter int unsigned PHASES = chroma_pkg::DEF_PHASES,
    parameter int unsigned HIGH   = chroma_pkg::DEF_HIGH,
    localparam int unsigned PW    = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_restart,
    input  logic [PW-1:0] restart_phase,
    input  logic          hue_req,
    input  logic [PW-1:0] hue_steps,
    input  logic          en,
    output logic          chroma_out,
    output logic [PW-1:0] phase_idx
);
    logic hold;

    chroma_stall_ctl #(.PHASES(PHASES)) u_stall (
        .clk(clk), .rst_n(rst_n), .burst_i(burst_restart),
        .hue_req_i(hue_req), .hue_steps_i(hue_steps), .hold_o(hold)
    );

    chroma_phase_ctr #(.PHASES(PHASES)) u_phase (
        .clk(clk), .rst_n(rst_n), .burst_i(burst_restart),
        .restart_phase_i(restart_phase), .hold_i(hold), .phase_o(phase_idx)
    );

    chroma_wave_shaper #(.PHASES(PHASES), .HIGH(HIGH)) u_wave (
        .phase_i(phase_idx), .en_i(en), .wave_o(chroma_out)
    );

    assert_chroma_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_out |-> (phase_idx < PW'(HIGH)));
    assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !chroma_out);
endmodule

// File: tb/test_chroma_subcarrier_gen.sv
module test_chroma_subcarrier_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_restart = 1'b0;
    logic [2:0] restart_phase = '0;
    logic hue_req = 1'b0;
    logic [2:0] hue_steps = '0;
    logic en = 1'b0;
    logic chroma_out;
    logic [2:0] phase_idx;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    chroma_subcarrier_gen i_chroma_subcarrier_gen (
        .clk(clk), .rst_n(rst_n), .burst_restart(burst_restart),
        .restart_phase(restart_phase), .hue_req(hue_req), .hue_steps(hue_steps),
        .en(en), .chroma_out(chroma_out), .phase_idx(phase_idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Load phase p with a burst; returns at the negedge where phase_idx == p.
    task automatic burst_to(input int p);
        restart_phase = 3'(p);
        burst_restart = 1'b1;
        step();
        burst_restart = 1'b0;
    endtask

    task automatic t_reset();
        en = 1'b0;
        rst_n = 1'b0;
        step(); step();
        check(phase_idx == 0, "R1 phase in reset", phase_idx, 0);
        check(chroma_out == 0, "R1 chroma in reset", chroma_out, 0);
        rst_n = 1'b1;
        step();
        check(phase_idx == 1, "R1 first count after reset", phase_idx, 1);
    endtask

    task automatic t_free_run();
        en = 1'b1;
        burst_to(0);
        for (int i = 1; i <= 14; i++) begin
            step();
            check(phase_idx == 3'(i % 7), "R2 free-run phase", phase_idx, i % 7);
            check(chroma_out == ((i % 7) < 3), "R3 chroma window", chroma_out, int'((i % 7) < 3));
        end
    endtask

    task automatic t_disabled();
        en = 1'b0;
        burst_to(2);
        for (int i = 1; i <= 9; i++) begin
            step();
            check(chroma_out == 0, "R4 chroma low when disabled", chroma_out, 0);
            check(phase_idx == 3'((2 + i) % 7), "R4 phase runs when disabled", phase_idx, (2 + i) % 7);
        end
        en = 1'b1;
    endtask

    task automatic t_restart_values();
        for (int v = 0; v < 8; v++) begin
            int e;
            e = (v > 6) ? 0 : v;
            burst_to(v);
            if (v > 6) check(phase_idx == 3'(e), "R6 out-of-range restart", phase_idx, e);
            else       check(phase_idx == 3'(e), "R5 restart load", phase_idx, e);
            step();
            check(phase_idx == 3'((e + 1) % 7), "R5 resume after restart", phase_idx, (e + 1) % 7);
        end
    endtask

    // Request stall of n (raw) cycles at phase 0, expect retard r after 10 edges.
    task automatic stall_case(input int n, input int r, input string tag);
        burst_to(0);
        hue_req = 1'b1;
        hue_steps = 3'(n);
        step();
        hue_req = 1'b0;
        for (int i = 2; i <= 10; i++) step();
        check(phase_idx == 3'((10 - r) % 7), tag, phase_idx, (10 - r) % 7);
    endtask

    task automatic t_stall_hold();
        burst_to(0);
        hue_req = 1'b1;
        hue_steps = 3'd4;
        for (int i = 1; i <= 4; i++) begin
            step();
            hue_req = 1'b0;
            check(phase_idx == 0, "R7 held during stall", phase_idx, 0);
        end
        step();
        check(phase_idx == 1, "R7 resumes after stall", phase_idx, 1);
    endtask

    task automatic t_stall_ignored();
        burst_to(0);
        hue_req = 1'b1;
        hue_steps = 3'd3;
        step();
        hue_steps = 3'd5;   // second request during the stall
        step();
        hue_req = 1'b0;
        for (int i = 3; i <= 10; i++) step();
        check(phase_idx == 3'((10 - 3) % 7), "R9 request during stall ignored", phase_idx, 0);
    endtask

    task automatic t_burst_priority();
        burst_to(0);
        hue_req = 1'b1;
        hue_steps = 3'd6;
        step();
        hue_req = 1'b0;
        step();
        burst_to(4);
        check(phase_idx == 4, "R11 burst during stall", phase_idx, 4);
        step();
        check(phase_idx == 5, "R11 stall cancelled", phase_idx, 5);
        restart_phase = 3'd2;
        burst_restart = 1'b1;
        hue_req = 1'b1;
        hue_steps = 3'd5;
        step();
        burst_restart = 1'b0;
        hue_req = 1'b0;
        check(phase_idx == 2, "R11 burst beats request", phase_idx, 2);
        step();
        check(phase_idx == 3, "R11 same-edge request dropped", phase_idx, 3);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_free_run();
        t_disabled();
        t_restart_values();
        t_stall_hold();
        stall_case(3, 3, "R7 retard by 3");
        stall_case(6, 6, "R7 retard by 6");
        stall_case(0, 0, "R8 zero-step request no effect");
        stall_case(7, 6, "R10 count 7 clamped to 6");
        t_stall_ignored();
        t_burst_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule